// File: doc/BRIEF.md
# ADC Sample Streaming Bridge

This block sits between a free-running 10-bit parallel ADC and a synchronous USB peripheral data bus. On every edge of the sample clock it registers one ADC code and writes it into a dual-clock FIFO. The same clock is forwarded to the converter as its sample clock. The read side runs from a transfer clock twice as fast as the sample clock, so a consumer that has stalled for a while can drain the backlog and catch up.

On the way out, each unsigned offset-binary code is turned into a signed 16-bit word. The bridge subtracts the mid-scale code and a fixed DC trim, then scales the result up by a power of two and clamps it to the signed 16-bit range. The trim removes the constant offset that a mismatched common-mode reference adds to the analog input.

The peripheral tells the bridge with a ready input when it can accept data. A word is taken from the FIFO only in a read-clock cycle where ready is high and data is present. The word then appears on the output bus two read cycles later, marked by a one-cycle valid strobe. If the FIFO fills, new samples are lost and a sticky overflow flag is raised in the read domain.

Top module: `adc_stream_bridge`

## Requirements
- R1: Each output word equals (code − 512 − TRIM) × 2^SHIFT with defaults TRIM = 67 and SHIFT = 6. Examples: code 579 gives 0, code 512 gives −4288, code 1023 gives 28416, code 67 gives −32768.
- R2: A result below −32768 is clamped to −32768 and a result above 32767 is clamped to 32767. With the default parameters, every code from 0 to 66 yields −32768.
- R3: While the FIFO is not full, every captured sample leaves exactly once, in capture order. The first sample after write reset is the code present at the first sample-clock edge with wr_rst low.
- R4: A word is taken from the FIFO only in a read cycle with sink_ready high and the FIFO not empty. out_valid pulses two read cycles after that cycle. When sink_ready has been low for two consecutive cycles, the next out_valid is low.
- R5: The read side delivers up to one word per read cycle. With the read clock at twice the sample rate, a backlog therefore shrinks by about one word every two read cycles.
- R6: The FIFO holds 2^ADDR_W samples (1024 by default). When it is full, new samples are dropped and the stored samples are kept and delivered in order. overflow rises in the read domain only after a sample has actually been dropped.
- R7: overflow stays high until reset; it is cleared only by reset.
- R8: In reset, and right after it, out_valid and overflow are low. No word is presented until the first written sample has passed the two-flop pointer synchroniser, which takes at least four read cycles after reset release.
- R9: adc_sample_clk is the write clock forwarded unchanged to the ADC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample clock (write domain) |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| adc_data | input | 10 | Offset-binary ADC code |
| adc_sample_clk | output | 1 | Sample clock forwarded to the ADC |
| rd_clk | input | 1 | Transfer clock (read domain), twice the sample rate |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| sink_ready | input | 1 | Peripheral can accept data this cycle |
| out_data | output | 16 | Signed, scaled, offset-trimmed sample |
| out_valid | output | 1 | Strobe marking each delivered word |
| overflow | output | 1 | Sticky flag: a sample was dropped while full |

## Verification
The conversion is tried with a short repeating list of codes. The list covers mid-scale, the trimmed zero point, full scale, zero, and the codes on either side of the clipping boundary (65, 66, 67), which separates a missing trim, a wrong shift and a missing clamp. A full 0–1023 ramp then checks every code and its capture order, so a lost, repeated or reordered word shows at once. Flow control is tried in four ways: a long stall followed by release, which checks both the quiet output and the fast drain; ready toggling every cycle, which checks that a matched rate never overflows; a stall long enough to fill the FIFO, which separates dropping new samples from overwriting old ones and checks when the flag rises; and resets, which check that the flag is sticky.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;

  // Clamp a signed value into [lo, hi].
  function automatic int sat_clip(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Binary to reflected Gray code.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/abr_sync2.sv
module abr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/abr_gray_ptr.sv
module abr_gray_ptr #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc,
  output logic [AW:0] bin,
  output logic [AW:0] gray
);
  import adc_bridge_pkg::*;

  localparam int PW = AW + 1;

  logic [AW:0]  bin_nxt;
  logic [31:0]  gray_wide;

  assign bin_nxt   = bin + PW'(inc);
  assign gray_wide = bin2gray(32'(bin_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nxt;
      gray <= gray_wide[AW:0];
    end
  end
endmodule

// File: rtl/abr_dpram.sv
module abr_dpram #(
  parameter int DW = 10,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/abr_convert.sv
module abr_convert #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 16,
  parameter int SHIFT = 6,
  parameter int TRIM  = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_code,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_word
);
  import adc_bridge_pkg::*;

  localparam int MID  = 1 << (IN_W - 1);
  localparam int MAXV = (1 << (OUT_W - 1)) - 1;
  localparam int MINV = -(1 << (OUT_W - 1));
  localparam int GAIN = 1 << SHIFT;

  int centred;
  int scaled;
  int clipped;

  always_comb begin
    centred = int'(in_code) - MID - TRIM;
    scaled  = centred * GAIN;
    clipped = sat_clip(scaled, MINV, MAXV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_word <= OUT_W'(clipped);
    end
  end
endmodule

// File: rtl/adc_stream_bridge.sv
module adc_stream_bridge #(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 16,
  parameter int ADDR_W   = 10,
  parameter int SHIFT    = 6,
  parameter int TRIM     = 67
) (
  input  logic                wr_clk,
  input  logic                wr_rst,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                adc_sample_clk,
  input  logic                rd_clk,
  input  logic                rd_rst,
  input  logic                sink_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_valid,
  output logic                overflow
);
  localparam int PW = ADDR_W + 1;

  // ---------------- write (sample) domain ----------------
  assign adc_sample_clk = wr_clk;

  logic [SAMPLE_W-1:0] cap_q;
  logic                cap_vld;
  logic [PW-1:0]       wr_bin, wr_gray, rd_gray_w;
  logic                wr_full, wr_en, wr_drop_sticky;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      cap_q   <= '0;
      cap_vld <= 1'b0;
    end else begin
      cap_q   <= adc_data;
      cap_vld <= 1'b1;
    end
  end

  // Full: write pointer one lap ahead of the synchronised read pointer.
  assign wr_full = (wr_gray == {~rd_gray_w[PW-1:PW-2], rd_gray_w[PW-3:0]});
  assign wr_en   = cap_vld & ~wr_full;

  always_ff @(posedge wr_clk) begin
    if (wr_rst)                 wr_drop_sticky <= 1'b0;
    else if (cap_vld & wr_full) wr_drop_sticky <= 1'b1;
  end

  abr_gray_ptr #(.AW(ADDR_W)) u_wptr (
    .clk (wr_clk), .rst (wr_rst), .inc (wr_en),
    .bin (wr_bin), .gray (wr_gray)
  );

  // ---------------- read (transfer) domain ----------------
  logic [PW-1:0]       rd_bin, rd_gray, wr_gray_r;
  logic                rd_empty, rd_take, rd_word_vld, drop_seen;
  logic [SAMPLE_W-1:0] rd_word;

  assign rd_empty = (rd_gray == wr_gray_r);
  assign rd_take  = sink_ready & ~rd_empty;

  abr_gray_ptr #(.AW(ADDR_W)) u_rptr (
    .clk (rd_clk), .rst (rd_rst), .inc (rd_take),
    .bin (rd_bin), .gray (rd_gray)
  );

  // ---------------- crossings ----------------
  abr_sync2 #(.W(PW)) u_sync_w2r (
    .clk (rd_clk), .rst (rd_rst), .d (wr_gray), .q (wr_gray_r)
  );

  abr_sync2 #(.W(PW)) u_sync_r2w (
    .clk (wr_clk), .rst (wr_rst), .d (rd_gray), .q (rd_gray_w)
  );

  abr_sync2 #(.W(1)) u_sync_ovf (
    .clk (rd_clk), .rst (rd_rst), .d (wr_drop_sticky), .q (drop_seen)
  );

  // ---------------- storage ----------------
  abr_dpram #(.DW(SAMPLE_W), .AW(ADDR_W)) u_mem (
    .wclk  (wr_clk), .we (wr_en), .waddr (wr_bin[ADDR_W-1:0]), .wdata (cap_q),
    .rclk  (rd_clk), .re (rd_take), .raddr (rd_bin[ADDR_W-1:0]), .rdata (rd_word)
  );

  always_ff @(posedge rd_clk) begin
    if (rd_rst) rd_word_vld <= 1'b0;
    else        rd_word_vld <= rd_take;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) overflow <= 1'b0;
    else        overflow <= overflow | drop_seen;
  end

  // ---------------- output conversion ----------------
  abr_convert #(
    .IN_W (SAMPLE_W), .OUT_W (OUT_W), .SHIFT (SHIFT), .TRIM (TRIM)
  ) u_conv (
    .clk      (rd_clk),
    .rst      (rd_rst),
    .in_vld   (rd_word_vld),
    .in_code  (rd_word),
    .out_vld  (out_valid),
    .out_word (out_data)
  );
endmodule

// File: rtl/adc_stream_bridge_chk.sv
module adc_stream_bridge_chk #(
  parameter int OUT_W = 16,
  parameter int SHIFT = 6
) (
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             sink_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_valid,
  input logic             overflow
);
  localparam logic [OUT_W-1:0] LOW_MASK = OUT_W'((1 << SHIFT) - 1);

  // R4: a strobe is always preceded, two cycles earlier, by ready
  a_r4_valid_after_ready: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_valid |-> $past(sink_ready, 2));

  // R4: two quiet ready cycles give a quiet output
  a_r4_stall_quiet: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!sink_ready && $past(!sink_ready)) |=> !out_valid);

  // R7: overflow never falls outside reset
  a_r7_overflow_sticky: assert property (@(posedge rd_clk) disable iff (rd_rst)
    overflow |=> overflow);

  // R8: reset clears the strobe and the flag
  a_r8_reset_quiet: assert property (@(posedge rd_clk)
    rd_rst |=> (!out_valid && !overflow));

  // R1: scaling leaves the low SHIFT bits of every word at zero
  a_r1_scaled_lsbs: assert property (@(posedge rd_clk) disable iff (rd_rst)
    out_valid |-> ((out_data & LOW_MASK) == '0));
endmodule

bind adc_stream_bridge adc_stream_bridge_chk u_chk (
  .rd_clk     (rd_clk),
  .rd_rst     (rd_rst),
  .sink_ready (sink_ready),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .overflow   (overflow)
);

// File: tb/adc_stream_bridge_bench.sv
module adc_stream_bridge_bench;
  localparam int HMASK = 4095;
  localparam int BIG   = 32'h7fffffff;

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       wr_rst = 1'b1;
  logic       rd_rst = 1'b1;
  logic [9:0] adc_data = '0;
  logic       sink_ready = 1'b0;
  logic       adc_sample_clk;
  logic [15:0] out_data;
  logic       out_valid;
  logic       overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 rd_clk = ~rd_clk;   // 125 MHz transfer clock
  always #8 wr_clk = ~wr_clk;   // half rate sample clock

  adc_stream_bridge u_adc_stream_bridge (
    .wr_clk (wr_clk), .wr_rst (wr_rst), .adc_data (adc_data),
    .adc_sample_clk (adc_sample_clk),
    .rd_clk (rd_clk), .rd_rst (rd_rst), .sink_ready (sink_ready),
    .out_data (out_data), .out_valid (out_valid), .overflow (overflow)
  );

  // Expected word from R1/R2.
  function automatic int expect_word(input logic [9:0] code);
    int v;
    v = (int'(code) - 512 - 67) * 64;
    if (v < -32768) v = -32768;
    if (v > 32767)  v = 32767;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ADC model: pattern list or ramp
  logic [9:0] pat [16];
  int  plen = 1;
  bit  ramp = 1'b0;
  int  gidx = 0;

  always @(negedge wr_clk) begin
    if (ramp) adc_data <= 10'(gidx);
    else      adc_data <= pat[gidx % plen];
    gidx++;
  end

  // Record of what the design captures on each sample edge
  logic [9:0] hist [4096];
  int n_cap = 0;

  always @(posedge wr_clk) begin
    if (wr_rst) n_cap = 0;
    else begin
      hist[n_cap & HMASK] = adc_data;
      n_cap++;
    end
  end

  // Peripheral-side monitor
  int exp_idx   = 0;
  int mon_limit = BIG;

  always @(negedge rd_clk) begin
    if (rd_rst) exp_idx = 0;
    else if (out_valid) begin
      if (exp_idx < mon_limit) begin
        int e;
        e = expect_word(hist[exp_idx & HMASK]);
        check($signed(out_data) == e, (e == -32768) ? "R2 clamp" : "R1/R3 word",
              int'($signed(out_data)), e);
      end
      exp_idx++;
    end
  end

  task automatic do_reset();
    @(negedge rd_clk);
    wr_rst = 1'b1; rd_rst = 1'b1; sink_ready = 1'b0;
    mon_limit = BIG;
    repeat (10) @(negedge rd_clk);
    check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
    check(overflow == 1'b0, "R8 flag in reset", int'(overflow), 0);
    @(negedge wr_clk);
    wr_rst = 1'b0; rd_rst = 1'b0; sink_ready = 1'b1;
    begin
      int early;
      early = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge rd_clk);
        if (out_valid) early++;
      end
      check(early == 0, "R8 no word before sync", early, 0);
    end
  endtask

  task automatic t_codes();
    ramp = 1'b0;
    pat[0] = 10'd512; pat[1] = 10'd579; pat[2] = 10'd1023; pat[3] = 10'd0;
    pat[4] = 10'd600; pat[5] = 10'd66;  pat[6] = 10'd67;   pat[7] = 10'd65;
    pat[8] = 10'd300; pat[9] = 10'd1;
    plen = 10;
    sink_ready = 1'b1;
    repeat (400) @(negedge rd_clk);
    check(n_cap - exp_idx <= 4, "R3 nothing lost", n_cap - exp_idx, 4);
    check(exp_idx > 150, "R3 words delivered", exp_idx, 150);
  endtask

  task automatic t_ramp();
    ramp = 1'b1;
    repeat (4200) @(negedge rd_clk);
    check(n_cap - exp_idx <= 4, "R3 ramp order", n_cap - exp_idx, 4);
    ramp = 1'b0;
  endtask

  task automatic t_stall_drain();
    int bad;
    int got;
    bad = 0; got = 0;
    @(negedge rd_clk);
    sink_ready = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge rd_clk);
      if (i >= 2 && out_valid) bad++;
    end
    check(bad == 0, "R4 quiet while stalled", bad, 0);
    sink_ready = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge rd_clk);
      if (out_valid) got++;
    end
    check(got >= 110, "R5 backlog drain rate", got, 110);
    repeat (400) @(negedge rd_clk);
    check(n_cap - exp_idx <= 4, "R5 caught up", n_cap - exp_idx, 4);
  endtask

  task automatic t_half_ready();
    for (int i = 0; i < 2000; i++) begin
      @(negedge rd_clk);
      sink_ready = (i % 2 == 0);
    end
    sink_ready = 1'b1;
    repeat (20) @(negedge rd_clk);
    check(overflow == 1'b0, "R6 no drop at matched rate", int'(overflow), 0);
    check(n_cap - exp_idx <= 4, "R4 lag after toggling", n_cap - exp_idx, 4);
  endtask

  task automatic t_overflow();
    @(negedge rd_clk);
    sink_ready = 1'b0;
    repeat (4) @(negedge rd_clk);
    mon_limit = exp_idx + 1024;
    repeat (1900) @(negedge rd_clk);
    check(overflow == 1'b0, "R6 flag before full", int'(overflow), 0);
    repeat (400) @(negedge rd_clk);
    check(overflow == 1'b1, "R6 flag after drop", int'(overflow), 1);
    sink_ready = 1'b1;
    repeat (2400) @(negedge rd_clk);
    check(exp_idx >= mon_limit, "R6 stored samples kept", exp_idx, mon_limit);
  endtask

  task automatic t_sticky();
    repeat (200) @(negedge rd_clk);
    check(overflow == 1'b1, "R7 flag sticky", int'(overflow), 1);
    do_reset();
    check(overflow == 1'b0, "R7 flag cleared by reset", int'(overflow), 0);
  endtask

  task automatic t_clock_fwd();
    @(posedge wr_clk); #1;
    check(adc_sample_clk == 1'b1, "R9 clock high", int'(adc_sample_clk), 1);
    @(negedge wr_clk); #1;
    check(adc_sample_clk == 1'b0, "R9 clock low", int'(adc_sample_clk), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pat[i] = 10'd512;
    do_reset();
    t_clock_fwd();
    t_codes();
    t_ramp();
    t_stall_drain();
    t_half_ready();
    t_overflow();
    t_sticky();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule